// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small 8-bit RISC controller. Whenever a subroutine call is made, or an interrupt forces a branch, the controller raises a push strobe with the current program-counter value. A return from a subroutine, a return from an interrupt or a return carrying a literal raises the pop strobe. The entry now on top always appears at the top-of-stack output, and the controller loads it into its program counter.

The number of levels is a parameter from 1 to 16, with a default of 8. The entries sit in a register array inside the block, so the stack uses no program memory and no data memory. The stack pointer is private to the block and cannot be read or written.

The pointer counts modulo the depth in both directions. A push past the last level overwrites the oldest entry, and a pop with nothing stored returns whatever that slot holds. The block raises no fault and no flag in either case. A power-on reset or a user reset returns the pointer to slot 0 and leaves the stored entries as they were.

Top module: `ret_stack`

## Requirements
- R1: After a cycle with push high and pop low, top_addr equals that cycle's push_addr from the next clock on.
- R2: Pops with no push between them return the earlier pushed values in reverse order of pushing (last in, first out).
- R3: The stack holds DEPTH entries. A push made while DEPTH entries are stored overwrites the oldest one, so that after DEPTH+1 pushes the next DEPTH-1 pops return the newer values in reverse order and the first value is gone. The internal pointer never leaves the range 0 to DEPTH-1.
- R4: A pop made when nothing is stored raises no error. It moves the pointer down modulo DEPTH and shows that slot's content, so DEPTH consecutive pops starting from any state bring the top back to the value shown before them.
- R5: When push and pop are high in the same cycle, the top entry is replaced by push_addr and the pointer does not move, so a later single pop shows the entry that lay under the replaced one.
- R6: In a cycle with neither push nor pop, top_addr and all stored entries keep their values.
- R7: Driving either por_n or usr_rst_n low returns the pointer to slot 0 and leaves every stored entry as it was. After reset, top_addr shows slot 0, and the first push writes slot 1. Reset takes effect at once and ends on the second clock edge after both inputs are high. Push and pop are ignored until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| usr_rst_n | input | 1 | User reset, active low, asynchronous |
| push | input | 1 | Push strobe (call or interrupt entry) |
| pop | input | 1 | Pop strobe (return instructions) |
| push_addr | input | AW | Program-counter value to store |
| top_addr | output | AW | Entry currently on top of the stack |

## Verification
The bench goes after the points where the pointer wraps.

- **Overflow.** Nine pushes into eight levels test the overflow wrap. A pointer that saturated would return the eighth value where the ninth is expected. A pointer that was not reduced modulo the depth would read a slot that does not exist.
- **Underflow.** Pops beyond the stored count test the underflow wrap. A design that clamped at zero would keep repeating one value instead of cycling through the slots.
- **Simultaneous push and pop.** The bench checks the entry shown by the next pop. A design that treated this case as a push or as a pop would show the wrong entry there.
- **Reset.** Resets in the middle of a sequence, from each source, must leave the stored entries intact and send the next push to slot 1. A design that cleared the array, or reset only on one input, would show the wrong value.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  // Operation seen by the pointer and the storage in one cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;

  // Pointer width; never below one bit so a single-level stack still elaborates
  function automatic int ptr_width(input int depth);
    int w;
    w = $clog2(depth);
    if (w < 1) w = 1;
    return w;
  endfunction

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    stk_op_e op;
    case ({pop, push})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ret_stack_rst.sv
// Combines the two reset sources: reset asserts at once, releases on the clock
module ret_stack_rst (
  input  logic clk,
  input  logic por_n,
  input  logic usr_rst_n,
  output logic rst_n_sync
);

  logic raw_n;
  logic meta_q;
  logic sync_q;

  assign raw_n = por_n & usr_rst_n;

  always_ff @(posedge clk or negedge raw_n) begin
    if (!raw_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/ret_stack_ptr.sv
// Top-of-stack pointer, counting modulo DEPTH in both directions
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_op_e       op,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] wr_idx
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic [PW-1:0] ptr_up;
  logic [PW-1:0] ptr_dn;
  logic          ptr_en;

  always_comb begin
    ptr_up = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
    ptr_dn = (ptr_q == '0) ? LAST : ptr_q - PW'(1);
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    wr_idx = ptr_up;
    case (op)
      OP_PUSH: begin
        ptr_d  = ptr_up;
        ptr_en = 1'b1;
      end
      OP_POP: begin
        ptr_d  = ptr_dn;
        ptr_en = 1'b1;
      end
      OP_SWAP: wr_idx = ptr_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/ret_stack_mem.sv
// Register array of return addresses; contents are not reset
module ret_stack_mem
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int PW = ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wdata,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0] slot_rd [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          slot_we;
    logic [AW-1:0] slot_q;

    assign slot_we = we && (wr_idx == PW'(g));

    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_q <= wdata;
      end
    end

    assign slot_rd[g] = slot_q;
  end

  always_comb begin
    rdata = slot_rd[0];
    for (int i = 1; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) rdata = slot_rd[i];
    end
  end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          usr_rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  localparam int PW = ptr_width(DEPTH);

  logic          rst_n_s;
  stk_op_e       op;
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] wr_idx;
  logic          mem_we;

  ret_stack_rst u_rst (
    .clk        (clk),
    .por_n      (por_n),
    .usr_rst_n  (usr_rst_n),
    .rst_n_sync (rst_n_s)
  );

  // Strobes count only once the synchronised reset has released
  assign op     = rst_n_s ? decode_op(push, pop) : OP_IDLE;
  assign mem_we = (op == OP_PUSH) || (op == OP_SWAP);

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .op     (op),
    .ptr    (ptr_q),
    .wr_idx (wr_idx)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk    (clk),
    .we     (mem_we),
    .wr_idx (wr_idx),
    .wdata  (push_addr),
    .rd_idx (ptr_q),
    .rdata  (top_addr)
  );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int PW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          pop,
  input logic [AW-1:0] push_addr,
  input logic [AW-1:0] top_addr,
  input logic [PW-1:0] ptr
);

  // R1: a lone push shows its value on the next cycle
  p_push_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (top_addr == $past(push_addr)));

  // R2: a pop right after a push shows the top from before the push
  if (DEPTH > 1) begin : g_lifo
    p_pop_after_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && $past(push && !pop)) |=> (top_addr == $past(top_addr, 2)));
  end

  // R3: pointer stays inside the array
  p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ptr) < DEPTH));

  // R5: simultaneous push and pop replaces the top and keeps the pointer
  p_swap_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (top_addr == $past(push_addr)));
  p_swap_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(ptr));

  // R6: idle cycle keeps the top and the pointer
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> ($stable(top_addr) && $stable(ptr)));

endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .push      (push),
  .pop       (pop),
  .push_addr (push_addr),
  .top_addr  (top_addr),
  .ptr       (ptr_q)
);

// File: tb/ret_stack_test.sv
`timescale 1ns/1ps
module ret_stack_test;

  localparam int DEPTH = 8;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          por_n;
  logic          usr_rst_n;
  logic          push;
  logic          pop;
  logic [AW-1:0] push_addr;
  logic [AW-1:0] top_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference: slot contents, known flags and a plain integer index
  logic [AW-1:0] m_val [DEPTH];
  bit            m_known [DEPTH];
  int            m_sp;

  ret_stack #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk       (clk),
    .por_n     (por_n),
    .usr_rst_n (usr_rst_n),
    .push      (push),
    .pop       (pop),
    .push_addr (push_addr),
    .top_addr  (top_addr)
  );

  always #5 clk = ~clk;

  task automatic check_val(input string tag, input logic [AW-1:0] act,
                           input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: top_addr=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock with the given strobes, model update, compare when the slot is known
  task automatic step(input bit ps, input bit pp, input logic [AW-1:0] d,
                      input string tag);
    push = ps; pop = pp; push_addr = d;
    @(posedge clk); #1;
    if (ps && pp) begin
      m_val[m_sp] = d; m_known[m_sp] = 1;
    end else if (ps) begin
      m_sp = (m_sp + 1) % DEPTH;
      m_val[m_sp] = d; m_known[m_sp] = 1;
    end else if (pp) begin
      m_sp = (m_sp + DEPTH - 1) % DEPTH;
    end
    push = 0; pop = 0; push_addr = '0;
    if (m_known[m_sp]) check_val(tag, top_addr, m_val[m_sp]);
  endtask

  task automatic do_reset(input bit use_por);
    if (use_por) por_n = 0; else usr_rst_n = 0;
    #1;
    m_sp = 0;
    if (m_known[0]) check_val("R7 reset asserted", top_addr, m_val[0]);
    @(posedge clk); #1;
    por_n = 1; usr_rst_n = 1;
    repeat (4) begin
      @(posedge clk); #1;
    end
    if (m_known[0]) check_val("R7 reset released", top_addr, m_val[0]);
  endtask

  initial begin
    por_n = 0; usr_rst_n = 1; push = 0; pop = 0; push_addr = '0;
    m_sp = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_known[i] = 0; m_val[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    por_n = 1;
    repeat (4) begin
      @(posedge clk); #1;
    end

    // R1 / R2: simple push then pop
    step(1, 0, 16'h1100, "R1 push a");
    step(1, 0, 16'h2200, "R1 push b");
    step(1, 0, 16'h3300, "R1 push c");
    step(0, 1, 16'h0000, "R2 pop to b");
    step(0, 1, 16'h0000, "R2 pop to a");
    step(1, 0, 16'h4400, "R1 push d");
    step(0, 1, 16'h0000, "R2 pop back to a");

    // R7: reset with por, slot 0 not yet written, then push lands in slot 1
    do_reset(1);
    step(1, 0, 16'h0A0A, "R7 first push after por");

    // R3: DEPTH+1 pushes overwrite the oldest
    for (int i = 0; i <= DEPTH; i++)
      step(1, 0, AW'(16'h5000 + i), "R3 overflow push");
    for (int i = 0; i < DEPTH - 1; i++)
      step(0, 1, 16'h0000, "R3 pop newer entries");
    // R4: keep popping past empty, wraps through the slots
    for (int i = 0; i < DEPTH + 3; i++)
      step(0, 1, 16'h0000, "R4 underflow pop wraps");

    // R5: simultaneous push and pop
    step(1, 0, 16'h6600, "R5 push base");
    step(1, 0, 16'h7700, "R5 push upper");
    step(1, 1, 16'h8800, "R5 swap top");
    step(0, 0, 16'h0000, "R6 idle after swap");
    step(0, 1, 16'h0000, "R5 pop under swapped");
    check_val("R5 entry below swap", top_addr, 16'h6600);

    // R6: several idle cycles with data wiggling
    for (int i = 0; i < 4; i++)
      step(0, 0, AW'(16'hBEE0 + i), "R6 idle hold");

    // R7: user reset mid-stack keeps contents, pointer back to slot 0
    do_reset(0);
    step(1, 0, 16'h9900, "R7 push after user reset");
    step(0, 1, 16'h0000, "R7 pop to slot 0");
    step(0, 1, 16'h0000, "R4 pop wraps to last slot");

    // R7: strobes during reset are ignored
    usr_rst_n = 0; push = 1; push_addr = 16'hDEAD;
    @(posedge clk); #1;
    push = 0; push_addr = '0;
    m_sp = 0;
    usr_rst_n = 1;
    repeat (4) begin
      @(posedge clk); #1;
    end
    check_val("R7 push during reset ignored", top_addr, m_val[0]);

    // R1 / R3: wrap a full loop once more with distinct data
    for (int i = 0; i < 2 * DEPTH; i++)
      step(1, 0, AW'(16'hC000 + 3 * i), "R3 double wrap push");
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, 16'h0000, "R2 pop after double wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: simulation hung, actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule